// File: doc/BRIEF.md
# S/PDIF channel status capture

This block gathers the 192-bit channel status block carried one bit per frame in a decoded S/PDIF stream. An upstream decoder delivers a one-cycle strobe per subframe together with a flag naming the subframe (A or B), the status bit from that subframe and a flag that marks the first frame of a status block. A configuration input chooses whether the A or the B subframes supply the status bits.

Bits are collected in a private shadow register, starting at the frame that carries the block-start flag. Only when all 192 bits are present is the whole block copied into the readable copy, so a reader never sees a mix of two blocks. The readable copy is presented as six 32-bit words; a 3-bit selector picks one of them onto a combinational read bus. Every one of the 192 bits is meaningful, so no validity mask is needed.

Top module: `spdif_cs_capture`

## Requirements
- R1: After reset every word reads as zero.
- R2: The n-th status bit captured after a block start (n = 0 for the start frame) is stored as bit n%8 of status byte n/8, and word i carries status byte 4*i+j on bits [8*j+7:8*j].
- R3: The readable words change only on the strobe that delivers the 192nd bit of a block; until then they keep the previous complete block.
- R4: With sel_chan_b = 0 only subframes with sf_chan_b = 0 (A) supply status bits; with sel_chan_b = 1 only subframes with sf_chan_b = 1 (B) do. Status bits of the other subframe have no effect.
- R5: A block-start flag on a subframe of the selected channel makes that subframe's bit bit 0; a block-start flag on a subframe of the other channel makes the next selected-channel subframe bit 0.
- R6: A block start that arrives before 192 bits have been collected discards the partial block and restarts the count at bit 0.
- R7: After a block has been published, selected-channel bits are ignored until the next block start.
- R8: word_sel values 6 and 7 read as zero.
- R9: word_data follows word_sel in the same cycle, without a register stage.
- R10: Inputs present while sf_valid is low, including the block-start flag, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_valid | input | 1 | One-cycle strobe, one per decoded subframe |
| sf_chan_b | input | 1 | Subframe flag: 0 = A, 1 = B |
| sf_cs_bit | input | 1 | Channel status bit of this subframe |
| sf_blk_start | input | 1 | Subframe belongs to the first frame of a status block |
| sel_chan_b | input | 1 | Source channel: 0 = A, 1 = B |
| word_sel | input | 3 | Index of the 32-bit status word to read |
| word_data | output | 32 | Selected status word |

## Verification
The properties assume the source selector is held steady while a block is being collected, and that each strobe describes exactly one subframe; the stimulus only changes sel_chan_b between blocks and drives strobes one cycle wide. Subframes always arrive as A/B pairs with the block-start flag on the A subframe, so the B-channel runs rely on the deferred start rule. The other channel always carries the complement of the captured bits and idle cycles carry a raised start flag with a wrong bit, so a leak from either shows up in the published words.

// File: rtl/spdif_cs_capture.sv
module spdif_cs_capture #(
  parameter int CS_BITS = 192,
  parameter int WORD_W  = 32,
  parameter int SEL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sf_valid,
  input  logic              sf_chan_b,
  input  logic              sf_cs_bit,
  input  logic              sf_blk_start,
  input  logic              sel_chan_b,
  input  logic [SEL_W-1:0]  word_sel,
  output logic [WORD_W-1:0] word_data
);
  localparam int NWORDS = CS_BITS / WORD_W;
  localparam int NSLOT  = 1 << SEL_W;
  localparam int CNT_W  = $clog2(CS_BITS);

  logic [CNT_W-1:0]   cnt, idx;
  logic               armed, pend;
  logic [CS_BITS-1:0] shadow, sh_nxt, pub;
  logic [WORD_W-1:0]  slot [NSLOT];

  wire take      = sf_valid && (sf_chan_b == sel_chan_b);
  wire start_now = take && (sf_blk_start || pend);
  wire wr        = take && (start_now || armed);
  wire last      = (idx == CNT_W'(CS_BITS - 1));

  assign idx = start_now ? '0 : cnt;

  always_comb begin
    sh_nxt      = shadow;
    sh_nxt[idx] = sf_cs_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      armed  <= 1'b0;
      pend   <= 1'b0;
      shadow <= '0;
      pub    <= '0;
    end else begin
      if (take)
        pend <= 1'b0;
      else if (sf_valid && sf_blk_start)
        pend <= 1'b1;
      if (wr) begin
        shadow <= sh_nxt;
        if (last) begin
          pub   <= sh_nxt;
          armed <= 1'b0;
          cnt   <= '0;
        end else begin
          armed <= 1'b1;
          cnt   <= idx + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g < NWORDS) begin : g_used
      assign slot[g] = pub[g*WORD_W +: WORD_W];
    end else begin : g_zero
      assign slot[g] = '0;
    end
  end

  assign word_data = slot[word_sel];
endmodule

// File: rtl/spdif_cs_capture_chk.sv
module spdif_cs_capture_chk #(
  parameter int CS_BITS = 192,
  parameter int WORD_W  = 32,
  parameter int SEL_W   = 3,
  parameter int CNT_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sf_valid,
  input logic               sf_chan_b,
  input logic               sf_blk_start,
  input logic               sel_chan_b,
  input logic [SEL_W-1:0]   word_sel,
  input logic [WORD_W-1:0]  word_data,
  input logic [CNT_W-1:0]   cnt,
  input logic               armed,
  input logic               pend,
  input logic [CS_BITS-1:0] pub
);
  localparam int NWORDS = CS_BITS / WORD_W;

  wire sel_sf   = sf_valid && (sf_chan_b == sel_chan_b);
  wire other_sf = sf_valid && (sf_chan_b != sel_chan_b);

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(CS_BITS));

  p_pub_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_sf |=> $stable(pub));

  p_other_chan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    other_sf |=> $stable(cnt) && $stable(armed));

  p_start_here_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_sf && sf_blk_start) |=> (cnt == CNT_W'(1)) && armed && !pend);

  p_start_defer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (other_sf && sf_blk_start) |=> pend);

  p_idle_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_sf && !sf_blk_start && !pend && !armed) |=> $stable(pub) && (cnt == '0));

  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_sel >= SEL_W'(NWORDS)) |-> (word_data == '0));

  p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_valid |=> $stable(pend) && $stable(cnt) && $stable(armed) && $stable(pub));
endmodule

bind spdif_cs_capture spdif_cs_capture_chk #(
  .CS_BITS(CS_BITS), .WORD_W(WORD_W), .SEL_W(SEL_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_chan_b(sf_chan_b),
  .sf_blk_start(sf_blk_start), .sel_chan_b(sel_chan_b), .word_sel(word_sel),
  .word_data(word_data), .cnt(cnt), .armed(armed), .pend(pend), .pub(pub)
);

// File: tb/test_spdif_cs_capture.sv
`timescale 1ns/1ps
module test_spdif_cs_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sf_valid = 1'b0, sf_chan_b = 1'b0, sf_cs_bit = 1'b0, sf_blk_start = 1'b0;
  logic        sel_chan_b = 1'b0;
  logic [2:0]  word_sel = '0;
  logic [31:0] word_data;
  int checks = 0, errors = 0, cur_seed = -1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spdif_cs_capture i_spdif_cs_capture (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_chan_b(sf_chan_b),
    .sf_cs_bit(sf_cs_bit), .sf_blk_start(sf_blk_start), .sel_chan_b(sel_chan_b),
    .word_sel(word_sel), .word_data(word_data)
  );

  function automatic logic pat(int seed, int n);
    return (((n * 5 + seed * 11 + (n >> 3) * 3 + n * n * seed) >> 2) % 2) == 1;
  endfunction

  function automatic logic [31:0] exp_word(int seed, int w);
    logic [31:0] v = '0;
    if (seed < 0 || w >= 6) return '0;
    for (int j = 0; j < 4; j++)
      for (int b = 0; b < 8; b++)
        v[8*j + b] = pat(seed, 8 * (4 * w + j) + b);
    return v;
  endfunction

  task automatic check_all(string tag);
    for (int w = 0; w < 8; w++) begin
      logic [31:0] e;
      word_sel = 3'(w);
      #1;
      e = exp_word(cur_seed, w);
      checks++;
      if (word_data !== e) begin
        errors++;
        $display("FAIL %s R9 word %0d: got %h expected %h%s", tag, w, word_data, e,
                 (w >= 6) ? " (R8)" : "");
      end
    end
  endtask

  task automatic send_sub(logic chan, logic bitv, logic start);
    sf_valid = 1'b1; sf_chan_b = chan; sf_cs_bit = bitv; sf_blk_start = start;
    @(negedge clk);
    sf_valid = 1'b0; sf_blk_start = 1'b0; sf_cs_bit = 1'b0; sf_chan_b = 1'b0;
  endtask

  task automatic send_frames(int seed, int n0, int n1, bit with_start, bit gaps);
    for (int n = n0; n < n1; n++) begin
      logic p = pat(seed, n);
      send_sub(1'b0, sel_chan_b ? !p : p, with_start && (n == n0));
      send_sub(1'b1, sel_chan_b ? p : !p, 1'b0);
      if (gaps) begin
        sf_valid = 1'b0; sf_blk_start = 1'b1; sf_chan_b = sel_chan_b; sf_cs_bit = !p;
        @(negedge clk);
        sf_blk_start = 1'b0; sf_cs_bit = 1'b0; sf_chan_b = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    sel_chan_b = 1'b0;
    send_frames(1, 0, 191, 1'b1, 1'b0);
    check_all("R3 191 bits held back");
    send_frames(1, 191, 192, 1'b0, 1'b0);
    cur_seed = 1;
    check_all("R2 R4 channel A block");

    sel_chan_b = 1'b1;
    send_frames(2, 0, 192, 1'b1, 1'b0);
    cur_seed = 2;
    check_all("R4 R5 channel B block, start on A");

    send_frames(3, 0, 100, 1'b1, 1'b0);
    check_all("R3 partial block invisible");
    send_frames(4, 0, 192, 1'b1, 1'b0);
    cur_seed = 4;
    check_all("R6 restart discards partial");

    send_frames(5, 0, 192, 1'b0, 1'b0);
    check_all("R7 no capture without start");

    sel_chan_b = 1'b0;
    send_frames(6, 0, 192, 1'b1, 1'b1);
    cur_seed = 6;
    check_all("R10 idle cycles ignored");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule